// File: doc/BRIEF.md
# Electrical Idle Inference Monitor

This block watches one lane of a serial-link receive stream that delivers four 8-bit symbols per clock, each with its own control flag. It decides that the lane has gone electrically idle when an expected event fails to appear within a timeout window. A 3-bit mode select picks what that event is: a clock-compensation or comma symbol, a training ordered set, or an exit from receiver electrical idle. A rate input selects first- or second-generation signalling, and each rule's window length depends on that rate.

All windows are counted in clock cycles. The long window is a plain cycle count set by the clock frequency. The unit-interval windows are divided by the unit intervals carried per cycle and rounded up. The result is a sticky inferred-idle flag and a one-cycle pulse when that flag sets. A link controller would change the mode select as it moves between training states and read the flag to decide when to leave a state.

Top module: `eidle_infer_mon`

## Requirements
- R1: When `mode_sel[2]` is 0 (any code 0xx), inference is off: the window counter stays at zero and `idle_inferred` and `idle_pulse` stay low.
- R2: Mode 3'b100, at either rate, reloads the window on any valid word holding a COM (control flag 1, byte 0xBC) or SKP (control flag 1, byte 0x1C) symbol in any of the four lanes. If neither arrives for WIN_128US_CYC cycles, the flag sets.
- R3: Mode 3'b101 reloads only on a training set: a COM symbol followed in the next symbol position by an identifier byte 0x4A or 0x45 with control flag 0. A COM alone does not reload. The window is ceil(UI_TS/UI_PER_CYC_G1) cycles at first generation and ceil(UI_TS/UI_PER_CYC_G2) at second generation.
- R4: A training set counts when its COM sits in lane 3 and its identifier sits in lane 0 of the next valid word.
- R5: Mode 3'b110 reloads on an electrical-idle exit, which is a high-to-low transition of `rx_eidle`. The window is ceil(UI_EXIT_G1/UI_PER_CYC_G1) cycles at first generation and ceil(UI_EXIT_G2/UI_PER_CYC_G2) at second generation.
- R6: Mode 3'b111 reloads on an electrical-idle exit with a window of WIN_128US_CYC cycles at first generation. At second generation the mode is off, as in R1.
- R7: Symbol i occupies `rx_data[8i+7:8i]` and its flag is `rx_datak[i]`, with lane 0 first in time. After a reload edge, the flag rises exactly W clock edges later if no further event arrives. A qualifying event clears the flag and restarts the count at the edge that samples it.
- R8: Once set, `idle_inferred` stays high until a qualifying event or a configuration change.
- R9: `idle_pulse` is high for exactly the one cycle in which `idle_inferred` first goes high.
- R10: Any change of `mode_sel` or `rate_gen2` restarts the window and clears the flag at the edge that samples the change.
- R11: Words with `rx_valid` low are ignored for symbol detection, including the carry of a lane-3 COM, but the window keeps counting through them.
- R12: A byte equal to 0xBC or 0x1C with control flag 0 is data and does not count as COM or SKP.
- R13: After reset, `idle_inferred` and `idle_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Inference rule select |
| rate_gen2 | input | 1 | 1 = second-generation rate, 0 = first |
| rx_data | input | 32 | Four received symbols, lane 0 in bits 7:0 |
| rx_datak | input | 4 | Control flag per symbol |
| rx_valid | input | 1 | Word qualifier |
| rx_eidle | input | 1 | Receiver electrical-idle indication |
| idle_inferred | output | 1 | Sticky inferred-idle flag |
| idle_pulse | output | 1 | One-cycle pulse when the flag sets |

## Verification
The bench builds the block with WIN_128US_CYC set to 60 so the long-window modes finish in a few dozen cycles. It sets UI_TS to 1290 so the training-set windows become 33 and 65 cycles, which exercises the round-up of a fractional division at both rates. The exit windows keep their defaults of 50 and 800 cycles, so the largest second-generation count is still run end to end. With these values every mode and rate can be taken through reload, expiry, stickiness and reconfiguration.

// File: rtl/eim_pkg.sv
package eim_pkg;

  localparam logic [7:0] SYM_COM = 8'hBC;
  localparam logic [7:0] SYM_SKP = 8'h1C;
  localparam logic [7:0] SYM_TS1 = 8'h4A;
  localparam logic [7:0] SYM_TS2 = 8'h45;

  typedef enum logic [1:0] {
    EVK_NONE   = 2'd0,
    EVK_COMSKP = 2'd1,
    EVK_TRAIN  = 2'd2,
    EVK_EXIT   = 2'd3
  } evt_kind_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic evt_kind_e kind_of(input logic [2:0] mode);
    if (!mode[2])            return EVK_NONE;
    else if (mode[1:0] == 2'b00) return EVK_COMSKP;
    else if (mode[1:0] == 2'b01) return EVK_TRAIN;
    else                     return EVK_EXIT;
  endfunction

endpackage

// File: rtl/eim_os_detect.sv
module eim_os_detect #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [8*LANES-1:0] rx_data,
  input  logic [LANES-1:0]   rx_datak,
  input  logic               rx_valid,
  output logic               comskp_hit,
  output logic               train_hit
);
  import eim_pkg::*;

  logic [LANES-1:0] is_com;
  logic [LANES-1:0] is_skp;
  logic [LANES-1:0] is_id;
  logic [LANES-1:0] pair_hit;
  logic             com_carry_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] sym;
    assign sym       = rx_data[8*i +: 8];
    assign is_com[i] = rx_valid && rx_datak[i] && (sym == SYM_COM);
    assign is_skp[i] = rx_valid && rx_datak[i] && (sym == SYM_SKP);
    assign is_id[i]  = rx_valid && !rx_datak[i] && ((sym == SYM_TS1) || (sym == SYM_TS2));
    if (i == 0) begin : g_first
      assign pair_hit[i] = com_carry_q && is_id[i];
    end else begin : g_rest
      assign pair_hit[i] = is_com[i-1] && is_id[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        com_carry_q <= 1'b0;
    else if (rx_valid) com_carry_q <= is_com[LANES-1];
  end

  assign comskp_hit = |(is_com | is_skp);
  assign train_hit  = |pair_hit;

endmodule

// File: rtl/eim_exit_detect.sv
module eim_exit_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_eidle,
  output logic exit_hit
);
  logic eidle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eidle_q <= 1'b0;
    else        eidle_q <= rx_eidle;
  end

  assign exit_hit = eidle_q && !rx_eidle;

endmodule

// File: rtl/eim_window_timer.sv
module eim_window_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] win_len,
  input  logic             restart,
  input  logic             reload,
  output logic             flag,
  output logic             pulse,
  output logic [CNT_W-1:0] cnt
);
  logic             off;
  logic             at_end;
  logic [CNT_W-1:0] last_idx;

  assign off      = (win_len == '0);
  assign last_idx = win_len - 1'b1;
  assign at_end   = (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else if (restart || off || reload) begin
      cnt   <= '0;
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else if (!flag) begin
      if (at_end) begin
        flag  <= 1'b1;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt + 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/eidle_infer_mon.sv
module eidle_infer_mon #(
  parameter int LANES         = 4,
  parameter int WIN_128US_CYC = 32000,
  parameter int UI_TS         = 1280,
  parameter int UI_EXIT_G1    = 2000,
  parameter int UI_EXIT_G2    = 16000,
  parameter int UI_PER_CYC_G1 = 40,
  parameter int UI_PER_CYC_G2 = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         mode_sel,
  input  logic               rate_gen2,
  input  logic [8*LANES-1:0] rx_data,
  input  logic [LANES-1:0]   rx_datak,
  input  logic               rx_valid,
  input  logic               rx_eidle,
  output logic               idle_inferred,
  output logic               idle_pulse
);
  import eim_pkg::*;

  localparam int unsigned W_LONG   = WIN_128US_CYC;
  localparam int unsigned W_TS_G1  = ceil_div(UI_TS, UI_PER_CYC_G1);
  localparam int unsigned W_TS_G2  = ceil_div(UI_TS, UI_PER_CYC_G2);
  localparam int unsigned W_EX_G1  = ceil_div(UI_EXIT_G1, UI_PER_CYC_G1);
  localparam int unsigned W_EX_G2  = ceil_div(UI_EXIT_G2, UI_PER_CYC_G2);
  localparam int unsigned W_MAX    = max2(max2(W_LONG, W_TS_G1),
                                          max2(max2(W_TS_G2, W_EX_G1), W_EX_G2));
  localparam int          CNT_W    = $clog2(W_MAX + 1);

  logic [3:0]       cfg_q;
  logic             cfg_change;
  evt_kind_e        kind;
  logic             comskp_hit;
  logic             train_hit;
  logic             exit_hit;
  logic             evt_sel;
  logic [CNT_W-1:0] win_len;
  logic [CNT_W-1:0] tmr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 4'd0;
    else        cfg_q <= {mode_sel, rate_gen2};
  end

  assign cfg_change = ({mode_sel, rate_gen2} != cfg_q);
  assign kind       = kind_of(mode_sel);

  eim_os_detect #(.LANES(LANES)) os_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_data    (rx_data),
    .rx_datak   (rx_datak),
    .rx_valid   (rx_valid),
    .comskp_hit (comskp_hit),
    .train_hit  (train_hit)
  );

  eim_exit_detect exit_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_eidle (rx_eidle),
    .exit_hit (exit_hit)
  );

  always_comb begin
    unique case (kind)
      EVK_COMSKP: begin
        evt_sel = comskp_hit;
        win_len = CNT_W'(W_LONG);
      end
      EVK_TRAIN: begin
        evt_sel = train_hit;
        win_len = rate_gen2 ? CNT_W'(W_TS_G2) : CNT_W'(W_TS_G1);
      end
      EVK_EXIT: begin
        evt_sel = exit_hit;
        if (mode_sel[0]) win_len = rate_gen2 ? '0 : CNT_W'(W_LONG);
        else             win_len = rate_gen2 ? CNT_W'(W_EX_G2) : CNT_W'(W_EX_G1);
      end
      default: begin
        evt_sel = 1'b0;
        win_len = '0;
      end
    endcase
  end

  eim_window_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_len (win_len),
    .restart (cfg_change),
    .reload  (evt_sel),
    .flag    (idle_inferred),
    .pulse   (idle_pulse),
    .cnt     (tmr_cnt)
  );

endmodule

// File: rtl/eim_checker.sv
module eim_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_sel,
  input logic             idle_inferred,
  input logic             idle_pulse,
  input logic             evt_sel,
  input logic             cfg_change,
  input logic [CNT_W-1:0] win_len,
  input logic [CNT_W-1:0] tmr_cnt
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel[2] && $past(!mode_sel[2])) |-> (!idle_inferred && !idle_pulse)); // R1

  AST_ZERO_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == '0 && !cfg_change) |-> (!idle_inferred && tmr_cnt == '0)); // R6

  AST_EVENT_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sel |=> (!idle_inferred && tmr_cnt == '0)); // R7

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len != '0 && !cfg_change) |-> (tmr_cnt < win_len)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idle_inferred) && !$past(evt_sel) && !$past(cfg_change)) |-> idle_inferred); // R8

  AST_PULSE_MARKS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_pulse == $rose(idle_inferred))); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> !idle_pulse); // R9

  AST_CFG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (!idle_inferred && !idle_pulse && tmr_cnt == '0)); // R10

endmodule

bind eidle_infer_mon eim_checker #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_sel      (mode_sel),
  .idle_inferred (idle_inferred),
  .idle_pulse    (idle_pulse),
  .evt_sel       (evt_sel),
  .cfg_change    (cfg_change),
  .win_len       (win_len),
  .tmr_cnt       (tmr_cnt)
);

// File: tb/eidle_infer_mon_tb_top.sv
module eidle_infer_mon_tb_top;

  localparam int CLK_PERIOD = 10;
  // Windows restated from the requirements for the bench build
  localparam int W_LONG  = 60;   // WIN_128US_CYC
  localparam int W_TS_G1 = 33;   // ceil(1290/40)
  localparam int W_TS_G2 = 65;   // ceil(1290/20)
  localparam int W_EX_G1 = 50;   // ceil(2000/40)
  localparam int W_EX_G2 = 800;  // ceil(16000/20)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'b000;
  logic        rate_gen2 = 1'b0;
  logic [31:0] rx_data = '0;
  logic [3:0]  rx_datak = '0;
  logic        rx_valid = 1'b1;
  logic        rx_eidle = 1'b0;
  logic        idle_inferred;
  logic        idle_pulse;

  logic [31:0] fill_data = '0;
  logic [3:0]  fill_k = '0;
  logic        fill_v = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eidle_infer_mon #(
    .WIN_128US_CYC (60),
    .UI_TS         (1290)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel      (mode_sel),
    .rate_gen2     (rate_gen2),
    .rx_data       (rx_data),
    .rx_datak      (rx_datak),
    .rx_valid      (rx_valid),
    .rx_eidle      (rx_eidle),
    .idle_inferred (idle_inferred),
    .idle_pulse    (idle_pulse)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill();
    rx_data = fill_data; rx_datak = fill_k; rx_valid = fill_v;
  endtask

  task automatic word1(input int lane, input logic [7:0] b, input logic k, input logic v);
    rx_data = '0; rx_datak = '0; rx_valid = v;
    rx_data[8*lane +: 8] = b; rx_datak[lane] = k;
  endtask

  // Reload stimulus already applied; next edge is the reload edge.
  task automatic run_window(input string req, input int w);
    tick(1);
    fill();
    chk(req, idle_inferred, 1'b0, "flag after reload");
    chk(req, idle_pulse, 1'b0, "pulse after reload");
    tick(w - 1);
    chk(req, idle_inferred, 1'b0, "flag one edge early");
    tick(1);
    chk(req, idle_inferred, 1'b1, "flag at window end");
    chk("R9", idle_pulse, 1'b1, "pulse at set");
    tick(1);
    chk("R8", idle_inferred, 1'b1, "flag held");
    chk("R9", idle_pulse, 1'b0, "pulse one cycle");
  endtask

  task automatic t_reset();
    chk("R13", idle_inferred, 1'b0, "flag in reset");
    rst_n = 1'b1;
    tick(2);
    chk("R13", idle_inferred, 1'b0, "flag after reset");
    chk("R13", idle_pulse, 1'b0, "pulse after reset");
  endtask

  task automatic t_disabled();
    tick(100);
    chk("R1", idle_inferred, 1'b0, "mode 000 long wait");
    mode_sel = 3'b011;
    tick(100);
    chk("R1", idle_inferred, 1'b0, "mode 011 long wait");
    chk("R1", idle_pulse, 1'b0, "mode 011 pulse");
  endtask

  task automatic t_comskp();
    mode_sel = 3'b100;
    run_window("R2", W_LONG);
    tick(20);
    chk("R8", idle_inferred, 1'b1, "sticky after 20 more");
    word1(2, 8'h1C, 1'b1, 1'b1);          // SKP lane 2
    run_window("R2", W_LONG);
    word1(0, 8'hBC, 1'b1, 1'b1);          // COM lane 0
    run_window("R7", W_LONG);
    rate_gen2 = 1'b1;                     // rate change restarts
    run_window("R10", W_LONG);
    word1(3, 8'hBC, 1'b1, 1'b1);          // COM lane 3 at Gen2
    run_window("R2", W_LONG);
  endtask

  task automatic t_ignored();
    // flag set in mode 100 gen2
    word1(1, 8'hBC, 1'b0, 1'b1);          // 0xBC as data
    tick(1);
    chk("R12", idle_inferred, 1'b1, "data 0xBC ignored");
    word1(3, 8'h1C, 1'b0, 1'b1);          // 0x1C as data
    tick(1);
    chk("R12", idle_inferred, 1'b1, "data 0x1C ignored");
    word1(0, 8'hBC, 1'b1, 1'b0);          // COM in invalid word
    tick(3);
    chk("R11", idle_inferred, 1'b1, "invalid COM ignored");
    // window still counts through invalid words full of COM
    fill_data = {4{8'hBC}}; fill_k = 4'hF; fill_v = 1'b0;
    word1(1, 8'h1C, 1'b1, 1'b1);
    run_window("R11", W_LONG);
    fill_data = '0; fill_k = '0; fill_v = 1'b1;
    fill();
  endtask

  task automatic t_train();
    mode_sel = 3'b101; rate_gen2 = 1'b0;
    run_window("R3", W_TS_G1);
    rx_data = 32'h0000_4ABC; rx_datak = 4'b0001; rx_valid = 1'b1;  // COM lane0, TS1 id lane1
    run_window("R3", W_TS_G1);
    word1(0, 8'hBC, 1'b1, 1'b1);          // COM alone
    tick(1);
    chk("R3", idle_inferred, 1'b1, "COM alone no reload");
    rate_gen2 = 1'b1;
    run_window("R3", W_TS_G2);
    rx_data = 32'h45BC_0000; rx_datak = 4'b0100; rx_valid = 1'b1;  // COM lane2, TS2 id lane3
    run_window("R3", W_TS_G2);
  endtask

  task automatic t_span();
    word1(3, 8'hBC, 1'b1, 1'b1);          // COM in lane 3
    tick(1);
    chk("R3", idle_inferred, 1'b1, "lane3 COM alone");
    word1(0, 8'h45, 1'b0, 1'b0);          // id in invalid word
    tick(1);
    chk("R11", idle_inferred, 1'b1, "invalid id ignored");
    word1(0, 8'h45, 1'b0, 1'b1);          // id in next valid word
    run_window("R4", W_TS_G2);
    word1(3, 8'hBC, 1'b1, 1'b1);
    tick(1);
    word1(0, 8'h4A, 1'b1, 1'b1);          // id with control flag set
    tick(1);
    chk("R4", idle_inferred, 1'b1, "control id rejected");
    fill();
  endtask

  task automatic t_exit();
    mode_sel = 3'b110; rate_gen2 = 1'b0;
    run_window("R5", W_EX_G1);
    rx_eidle = 1'b1;
    tick(3);
    chk("R5", idle_inferred, 1'b1, "eidle rise is not exit");
    rx_eidle = 1'b0;
    run_window("R5", W_EX_G1);
    rate_gen2 = 1'b1;
    run_window("R5", W_EX_G2);
    rx_eidle = 1'b1;
    tick(2);
    rx_eidle = 1'b0;
    run_window("R5", W_EX_G2);
  endtask

  task automatic t_long_exit();
    rate_gen2 = 1'b0; mode_sel = 3'b111;
    run_window("R6", W_LONG);
    rx_eidle = 1'b1;
    tick(2);
    rx_eidle = 1'b0;
    run_window("R6", W_LONG);
    rate_gen2 = 1'b1;
    tick(1);
    chk("R10", idle_inferred, 1'b0, "rate change clears");
    tick(200);
    chk("R6", idle_inferred, 1'b0, "mode 111 gen2 off");
    chk("R6", idle_pulse, 1'b0, "mode 111 gen2 pulse");
    mode_sel = 3'b000; rate_gen2 = 1'b0;
    tick(1);
    chk("R1", idle_inferred, 1'b0, "back to off");
  endtask

  initial begin
    tick(3);
    t_reset();
    t_disabled();
    t_comskp();
    t_ignored();
    t_train();
    t_span();
    t_exit();
    t_long_exit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule